// File: doc/BRIEF.md
# Rate-Trimmed Time-of-Day Counter

This block keeps a 64-bit time-of-day count in which one unit stands for 8 ns. On every clock cycle the count advances by a whole step taken from a 32-bit rate word, where 0x8000_0000 means one unit per cycle. Rate words above or below that value speed the count up or slow it down in proportion, and a fractional phase accumulator carries the remainder from cycle to cycle.

Software drives the block through a small register port with 32-bit data. A command word carries three things: a valid flag, a sticky mode bit that picks overwrite or offset for the next clock value write, and a one-shot clear request. The 64-bit clock value is written as a low half into a staging register, followed by a high half that commits the whole value. A read of the low half captures all 64 bits, so the high half that comes back afterwards belongs to the same instant.

Top module: `ptp_tick_counter`

## Requirements
- R1: After reset `time_now` is 0, the rate register (address 1) reads 0x8000_0000 and the command register (address 0) reads 0, so the mode bit is set-mode.
- R2: With the rate at 0x8000_0000 and no write in progress, `time_now` grows by exactly 1 per cycle.
- R3: Each cycle the step is rate bit 31 plus one more whenever the sum of rate bits 30:0 and a 31-bit phase accumulator reaches 2^31. For example 0xC000_0000 gives 3 units per 2 cycles, 0x4000_0000 gives 1 unit per 2 cycles, and a write to address 1 affects steps from the next cycle on.
- R4: A write to address 0 whose bit 31 (valid) is 0 changes nothing: the mode keeps its value and the count keeps running.
- R5: A valid command write copies data bit 0 into the mode bit (0 = set, 1 = add). The bit holds its value until the next valid command write, and address 0 reads it back in bit 0.
- R6: A valid command write with the clear bit set (bit 2 when LAYOUT=0, bit 3 when LAYOUT=1) makes `time_now` 0 at that edge and clears the phase accumulator. The bit at the other position has no effect.
- R7: A write to address 2 stages the low 32 bits. In set mode, a write to address 3 then loads `time_now` with {address-3 data, staged low} at that edge.
- R8: In add mode a write to address 3 treats {data, staged low} as a two's-complement offset and loads `time_now` with the old count plus that cycle's step plus the offset.
- R9: A read of address 2 returns the low 32 bits of the count in the read cycle and captures the high 32 bits at the same moment. A later read of address 3 returns those captured bits even if the count has carried since. Read data appears on `rd_data` one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 command, 1 rate, 2 value low, 3 value high |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 32 | Read data, valid one cycle after `rd_en` |
| time_now | output | 64 | Current count in 8 ns units |

## Verification
Command, clear and clock value writes take effect at the rising edge that samples `wr_en`, so the bench reads `time_now` at the falling edge just after that edge. A new rate word first shapes the step one edge later, and the bench counts its steps from the falling edge after the write. Read results arrive one edge after `rd_en`: the driver queues each expected word when it raises the strobe, and the monitor takes it from the queue at the following falling edge.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int ADDR_W      = 2;
    localparam int MODE_POS    = 0;
    localparam int CLR_POS_A   = 2;
    localparam int CLR_POS_B   = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CMD  = 2'd0,
        REG_RATE = 2'd1,
        REG_VLO  = 2'd2,
        REG_VHI  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/tc_regs.sv
module tc_regs import tc_pkg::*; #(
    parameter int DATA_W = 32,
    parameter int LAYOUT = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                mode,
    output logic [DATA_W-1:0]   rate,
    output logic [DATA_W-1:0]   stage_lo,
    output logic                clr_pulse,
    output logic                commit_pulse,
    output logic [2*DATA_W-1:0] commit_val
);
    localparam int VALID_POS = DATA_W - 1;
    localparam logic [DATA_W-1:0] RATE_NOM = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic              mode;
        logic [DATA_W-1:0] rate;
        logic [DATA_W-1:0] stage;
    } regs_t;

    regs_t st_d, st_q;
    logic  clr_bit;
    logic  cmd_ok;

    generate
        if (LAYOUT == 0) begin : g_clr_a
            assign clr_bit = wr_data[CLR_POS_A];
        end else begin : g_clr_b
            assign clr_bit = wr_data[CLR_POS_B];
        end
    endgenerate

    always_comb begin
        st_d   = st_q;
        cmd_ok = wr_en && (wr_addr == REG_CMD) && wr_data[VALID_POS];
        if (cmd_ok) begin
            st_d.mode = wr_data[MODE_POS];
        end
        if (wr_en && (wr_addr == REG_RATE)) begin
            st_d.rate = wr_data;
        end
        if (wr_en && (wr_addr == REG_VLO)) begin
            st_d.stage = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= 1'b0;
            st_q.rate  <= RATE_NOM;
            st_q.stage <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode         = st_q.mode;
    assign rate         = st_q.rate;
    assign stage_lo     = st_q.stage;
    assign clr_pulse    = cmd_ok && clr_bit;
    assign commit_pulse = wr_en && (wr_addr == REG_VHI);
    assign commit_val   = {wr_data, st_q.stage};
endmodule

// File: rtl/tc_rate_acc.sv
module tc_rate_acc #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [DATA_W-1:0] rate,
    output logic [1:0]        step
);
    localparam int FRAC_W = DATA_W - 1;

    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } acc_t;

    acc_t              st_d, st_q;
    logic [DATA_W-1:0] frac_sum;

    always_comb begin
        frac_sum = {1'b0, st_q.acc} + {1'b0, rate[FRAC_W-1:0]};
        step     = {1'b0, rate[DATA_W-1]} + {1'b0, frac_sum[DATA_W-1]};
        st_d.acc = clr ? '0 : frac_sum[FRAC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.acc <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tc_counter.sv
module tc_counter #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              commit,
    input  logic              add_mode,
    input  logic [TIME_W-1:0] value,
    input  logic [1:0]        step,
    output logic [TIME_W-1:0] count
);
    typedef struct packed {
        logic [TIME_W-1:0] cnt;
    } cnt_t;

    cnt_t              st_d, st_q;
    logic [TIME_W-1:0] advanced;

    always_comb begin
        advanced = st_q.cnt + {{(TIME_W-2){1'b0}}, step};
        st_d     = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (commit) begin
            st_d.cnt = add_mode ? (advanced + value) : value;
        end else begin
            st_d.cnt = advanced;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/tc_readback.sv
module tc_readback import tc_pkg::*; #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [2*DATA_W-1:0] count,
    input  logic                mode,
    input  logic [DATA_W-1:0]   rate,
    output logic [DATA_W-1:0]   rd_data
);
    typedef struct packed {
        logic [DATA_W-1:0] snap_hi;
        logic [DATA_W-1:0] rdata;
    } rb_t;

    rb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            unique case (rd_addr)
                REG_CMD:  st_d.rdata = {{(DATA_W-1){1'b0}}, mode};
                REG_RATE: st_d.rdata = rate;
                REG_VLO: begin
                    st_d.rdata   = count[DATA_W-1:0];
                    st_d.snap_hi = count[2*DATA_W-1:DATA_W];
                end
                default:  st_d.rdata = st_q.snap_hi;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdata;
endmodule

// File: rtl/ptp_tick_counter.sv
module ptp_tick_counter import tc_pkg::*; #(
    parameter int DATA_W = 32,
    parameter int LAYOUT = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [2*DATA_W-1:0] time_now
);
    localparam int TIME_W  = 2 * DATA_W;
    localparam int CLR_POS = (LAYOUT == 0) ? CLR_POS_A : CLR_POS_B;

    logic              mode_w;
    logic [DATA_W-1:0] rate_w;
    logic [DATA_W-1:0] stage_w;
    logic              clr_w;
    logic              commit_w;
    logic [TIME_W-1:0] commit_val_w;
    logic [1:0]        step_w;

    tc_regs #(.DATA_W(DATA_W), .LAYOUT(LAYOUT)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .mode         (mode_w),
        .rate         (rate_w),
        .stage_lo     (stage_w),
        .clr_pulse    (clr_w),
        .commit_pulse (commit_w),
        .commit_val   (commit_val_w)
    );

    tc_rate_acc #(.DATA_W(DATA_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_w),
        .rate  (rate_w),
        .step  (step_w)
    );

    tc_counter #(.TIME_W(TIME_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_w),
        .commit   (commit_w),
        .add_mode (mode_w),
        .value    (commit_val_w),
        .step     (step_w),
        .count    (time_now)
    );

    tc_readback #(.DATA_W(DATA_W)) u_rb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .count   (time_now),
        .mode    (mode_w),
        .rate    (rate_w),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
    parameter int DATA_W  = 32,
    parameter int CLR_POS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [1:0]          wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic                mode,
    input logic [DATA_W-1:0]   rate,
    input logic [DATA_W-1:0]   stage_lo,
    input logic [2*DATA_W-1:0] time_now
);
    localparam int TIME_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] RATE_NOM = {1'b1, {(DATA_W-1){1'b0}}};

    // R2: nominal rate gives one unit per cycle
    p_nominal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && rate == RATE_NOM) |=> time_now == $past(time_now) + 1);

    // R3: free-running step is the whole part or one more
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=>
            ((time_now - $past(time_now)) == TIME_W'($past(rate[DATA_W-1]))) ||
            ((time_now - $past(time_now)) == TIME_W'($past(rate[DATA_W-1])) + 1));

    // R4: command without valid flag leaves the mode alone
    p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && !wr_data[DATA_W-1]) |=> mode == $past(mode));

    // R5: mode only moves on a command write
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 2'd0) |=> $stable(mode));

    // R6: valid clear request zeroes the count
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && wr_data[DATA_W-1] && wr_data[CLR_POS]) |=> time_now == '0);

    // R7: set-mode commit loads the assembled value
    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3 && !mode) |=> time_now == {$past(wr_data), $past(stage_lo)});
endmodule

bind ptp_tick_counter tc_checker #(.DATA_W(DATA_W), .CLR_POS(CLR_POS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mode     (mode_w),
    .rate     (rate_w),
    .stage_lo (stage_w),
    .time_now (time_now)
);

// File: tb/ptp_tick_counter_tb.sv
module ptp_tick_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] time_now;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    ptp_tick_counter u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .time_now(time_now)
    );

    always #10 clk = ~clk;

    // reference model built from the requirements
    logic [63:0] m_t;
    logic [30:0] m_acc;
    logic [31:0] m_rate;
    logic        m_mode;
    logic [31:0] m_stage;
    logic [31:0] m_fsum;
    logic [63:0] m_step;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_t = '0; m_acc = '0; m_rate = 32'h8000_0000; m_mode = 1'b0; m_stage = '0;
        end else begin
            m_fsum = {1'b0, m_acc} + {1'b0, m_rate[30:0]};
            m_step = 64'(m_rate[31]) + 64'(m_fsum[31]);
            m_acc  = m_fsum[30:0];
            if (wr_en && wr_addr == 2'd0 && wr_data[31] && wr_data[2]) begin
                m_t = '0; m_acc = '0;
            end else if (wr_en && wr_addr == 2'd3) begin
                m_t = m_mode ? (m_t + m_step + {wr_data, m_stage}) : {wr_data, m_stage};
            end else begin
                m_t = m_t + m_step;
            end
            if (wr_en && wr_addr == 2'd0 && wr_data[31]) m_mode = wr_data[0];
            if (wr_en && wr_addr == 2'd1) m_rate = wr_data;
            if (wr_en && wr_addr == 2'd2) m_stage = wr_data;
        end
    end

    // scoreboard for reads
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          rd_pend = 1'b0;

    always @(posedge clk) rd_pend = rd_en;

    always @(negedge clk) begin
        if (rd_pend) begin
            rd_pend = 1'b0;
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL %s: read with empty queue, actual %h expected none", "R9", rd_data);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    bad++;
                    $display("FAIL %s: rd_data actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // all driver tasks start and end at a falling edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] t0;
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        check("R1", time_now, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", time_now, 64'd1);
        rd(2'd0, 32'h0, "R1");
        rd(2'd1, 32'h8000_0000, "R1");

        t0 = time_now;
        idle(10);
        check("R2", time_now, t0 + 64'd10);

        // rate trims
        wr(2'd1, 32'hC000_0000);
        t0 = time_now;
        idle(8);
        check("R3", time_now, t0 + 64'd12);
        wr(2'd1, 32'h4000_0000);
        t0 = time_now;
        idle(8);
        check("R3", time_now, t0 + 64'd4);
        wr(2'd1, 32'hFFFF_FFFF);
        idle(20);
        check("R3", time_now, m_t);
        wr(2'd1, 32'h8000_0000);
        rd(2'd1, 32'h8000_0000, "R3");

        // command without valid flag
        wr(2'd0, 32'h0000_000D);
        check("R4", time_now, m_t);
        total++;
        if (time_now == 64'd0) begin
            bad++;
            $display("FAIL R4: actual %h expected nonzero", time_now);
        end
        rd(2'd0, 32'h0, "R4");

        // clear request
        wr(2'd0, 32'h8000_0004);
        check("R6", time_now, 64'd0);
        idle(1);
        check("R6", time_now, 64'd1);
        t0 = time_now;
        wr(2'd0, 32'h8000_0008);
        check("R6", time_now, t0 + 64'd1);

        // set-mode commit
        wr(2'd2, 32'h89AB_CDEF);
        wr(2'd3, 32'h0123_4567);
        check("R7", time_now, 64'h0123_4567_89AB_CDEF);
        idle(1);
        check("R7", time_now, 64'h0123_4567_89AB_CDF0);

        // snapshot across a carry
        wr(2'd2, 32'hFFFF_FFFE);
        wr(2'd3, 32'h0000_0005);
        snap = m_t[63:32];
        rd(2'd2, m_t[31:0], "R9");
        idle(3);
        check("R9", {32'd0, time_now[63:32]}, 64'd6);
        rd(2'd3, snap, "R9");

        // sticky add mode
        wr(2'd0, 32'h8000_0001);
        rd(2'd0, 32'h1, "R5");
        wr(2'd0, 32'h0000_0000);
        rd(2'd0, 32'h1, "R5");

        // add negative offset
        wr(2'd2, 32'hFFFF_FF9C);
        t0 = time_now;
        wr(2'd3, 32'hFFFF_FFFF);
        check("R8", time_now, t0 + 64'd1 - 64'd100);
        // add positive offset
        wr(2'd2, 32'd1000);
        t0 = time_now;
        wr(2'd3, 32'd0);
        check("R8", time_now, t0 + 64'd1001);

        wr(2'd0, 32'h8000_0000);
        rd(2'd0, 32'h0, "R5");
        check("R5", time_now, m_t);
        idle(2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule